// File: doc/BRIEF.md
# Outbound MMIO window decoder

This block sits on the outbound side of a PCI Express host bridge. It takes a CPU-side MMIO address and decides which forwarding window, if any, claims it. It then produces the address to place on the PCIe link and the partition number that owns the access. Partition numbers are what the bridge uses to isolate devices from one another and to freeze a misbehaving one.

There are two kinds of window. The narrow window covers up to 4 GB. It rewrites every address bit above its size with a programmed value, which yields 32-bit bus addresses. It divides itself into equal segments and looks each one up in a table to find the partition. The wide windows, sixteen by default, forward the address unchanged. In segmented mode a wide window uses the segment index directly as the partition number; in whole mode it gives every address a single programmed partition. Wide windows beat the narrow one, and a lower-numbered wide window beats a higher-numbered one. Every window is a naturally aligned power of two, so the base bits below the size are ignored.

Windows and the segment table are set through a simple write port. Each lookup is registered, so the result appears on the cycle after the request.

Top module: `mmio_win_decoder`

## Requirements
- R1: After reset every window is disabled and every segment-table entry holds partition 0, so any lookup misses until a window is enabled.
- R2: A lookup presented with `req_valid` high produces `rsp_valid` high on the next cycle, with results for that address. A cycle without a request is followed by `rsp_valid` low. Back-to-back requests are each answered in turn.
- R3: Wide window k claims an address when it is enabled and the address bits at and above its size equal the same bits of its base; base bits below the size are ignored. A size code below `W64_MIN_LOG2` is stored as `W64_MIN_LOG2`, and one above `AW` is stored as `AW`.
- R4: A hit in a wide window returns `rsp_pci_addr` equal to the request address.
- R5: A segmented wide window of size 2^L returns the partition (address offset within the window) >> (L - log2(NSEG)).
- R6: An unsegmented wide window returns its programmed partition for every address it claims.
- R7: When several wide windows claim an address, the lowest-numbered one wins and its index is reported on `rsp_win`.
- R8: The narrow window is used only when no wide window claims the address, and it is reported as `rsp_win` = N64.
- R9: A narrow-window hit of size 2^L returns address bits [L-1:0] from the request, bits [31:L] from the replacement value, and zero above bit 31. The replacement bits below L have no effect. The size code is clamped to the range [`W32_MIN_LOG2`, 32].
- R10: The narrow-window partition is the segment-table entry at index (offset >> (L - log2(NSEG))).
- R11: A miss returns `rsp_hit`=0, `rsp_pe`=0, `rsp_pci_addr`=0 and `rsp_win`=0.
- R12: Configuration encoding. `cfg_addr[10:8]` selects the target: 0 = narrow base, 1 = narrow control, 2 = segment table, 3 = wide base, 4 = wide control. `cfg_addr[7:0]` gives the table entry or the wide-window index. Base writes use `cfg_wdata[AW-1:0]`. Narrow control uses enable in bit 0, size code in [13:8] and replacement in [63:32]. Wide control uses enable in bit 0, segmented mode in bit 1, size code in [13:8] and partition in [23:16]. Table writes take the partition in [PEW-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 11 | Configuration target select and index |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | AW | CPU-side MMIO address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Some window claimed the address |
| rsp_win | output | WINW | Winning window: wide index, or N64 for the narrow window |
| rsp_pe | output | PEW | Partition number |
| rsp_pci_addr | output | AW | Address forwarded to PCIe |

## Verification
The bench builds the decoder with four wide windows and a 1 MB minimum wide-window size, keeping `AW`=48 and 256 segments. Four windows are enough to place overlapping wide windows against each other and against the narrow window, and to reach the narrow window's index code N64=4. The small minimum size lets a clamped size code be checked at both edges of a window, down to its last segment, using short address literals. Segment arithmetic at full 256-segment resolution is exercised in both window kinds.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

   localparam int CFG_SELW = 3;
   localparam int CFG_IDXW = 8;
   localparam int CFG_AW   = CFG_SELW + CFG_IDXW;
   localparam int CFG_DW   = 64;
   localparam int LGW      = 6;

   typedef enum logic [CFG_SELW-1:0] {
      SEL_N_BASE = 3'd0,
      SEL_N_CTRL = 3'd1,
      SEL_SEGTAB = 3'd2,
      SEL_W_BASE = 3'd3,
      SEL_W_CTRL = 3'd4
   } cfg_sel_e;

   // Bring a programmed size code into the legal range of a window kind.
   function automatic logic [LGW-1:0] clamp_lg(input logic [LGW-1:0] v,
                                               input int lo, input int hi);
      if (int'(v) < lo) return LGW'(lo);
      if (int'(v) > hi) return LGW'(hi);
      return v;
   endfunction

endpackage

// File: rtl/mwd_seg_table.sv
module mwd_seg_table #(
   parameter int NSEG = 256,
   parameter int PEW  = 8,
   localparam int SEGB = $clog2(NSEG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [SEGB-1:0] widx,
   input  logic [PEW-1:0]  wpe,
   input  logic [SEGB-1:0] ridx,
   output logic [PEW-1:0]  rpe
);

   logic [PEW-1:0] tab_q [NSEG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NSEG; i++) tab_q[i] <= '0;
      end else if (we) begin
         tab_q[widx] <= wpe;
      end
   end

   assign rpe = tab_q[ridx];

endmodule

// File: rtl/mwd_win_wide.sv
module mwd_win_wide #(
   parameter int AW   = 48,
   parameter int PEW  = 8,
   parameter int SEGB = 8,
   parameter int MINL = 28
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_base,
   input  logic                     we_ctrl,
   input  logic [AW-1:0]            d_base,
   input  logic                     d_en,
   input  logic                     d_segm,
   input  logic [mwd_pkg::LGW-1:0]  d_lg,
   input  logic [PEW-1:0]           d_pe,
   input  logic [AW-1:0]            addr,
   output logic                     hit,
   output logic [PEW-1:0]           pe
);
   import mwd_pkg::*;

   logic            en_q, segm_q;
   logic [LGW-1:0]  lg_q;
   logic [AW-1:0]   base_q;
   logic [PEW-1:0]  pe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         segm_q <= 1'b0;
         lg_q   <= LGW'(MINL);
         base_q <= '0;
         pe_q   <= '0;
      end else begin
         if (we_base) base_q <= d_base;
         if (we_ctrl) begin
            en_q   <= d_en;
            segm_q <= d_segm;
            lg_q   <= clamp_lg(d_lg, MINL, AW);
            pe_q   <= d_pe;
         end
      end
   end

   logic [AW-1:0]   hmask;
   logic [AW-1:0]   offs;
   logic [LGW-1:0]  shamt;
   logic [SEGB-1:0] seg;

   always_comb begin
      for (int b = 0; b < AW; b++) hmask[b] = (b >= int'(lg_q));
   end

   assign offs  = addr & ~hmask;
   assign shamt = lg_q - LGW'(SEGB);
   assign seg   = SEGB'(offs >> shamt);
   assign hit   = en_q && (((addr ^ base_q) & hmask) == '0);
   assign pe    = segm_q ? PEW'(seg) : pe_q;

endmodule

// File: rtl/mwd_win_narrow.sv
module mwd_win_narrow #(
   parameter int AW   = 48,
   parameter int SEGB = 8,
   parameter int MINL = 16,
   localparam int MAXL = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_base,
   input  logic                     we_ctrl,
   input  logic [AW-1:0]            d_base,
   input  logic                     d_en,
   input  logic [mwd_pkg::LGW-1:0]  d_lg,
   input  logic [MAXL-1:0]          d_repl,
   input  logic [AW-1:0]            addr,
   output logic                     hit,
   output logic [SEGB-1:0]          seg,
   output logic [AW-1:0]            pci
);
   import mwd_pkg::*;

   logic            en_q;
   logic [LGW-1:0]  lg_q;
   logic [AW-1:0]   base_q;
   logic [MAXL-1:0] repl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         lg_q   <= LGW'(MAXL);
         base_q <= '0;
         repl_q <= '0;
      end else begin
         if (we_base) base_q <= d_base;
         if (we_ctrl) begin
            en_q   <= d_en;
            lg_q   <= clamp_lg(d_lg, MINL, MAXL);
            repl_q <= d_repl;
         end
      end
   end

   logic [AW-1:0]   hmask;
   logic [AW-1:0]   offs;
   logic [LGW-1:0]  shamt;
   logic [MAXL-1:0] low_keep;

   always_comb begin
      for (int b = 0; b < AW; b++) hmask[b] = (b >= int'(lg_q));
   end

   assign offs     = addr & ~hmask;
   assign shamt    = lg_q - LGW'(SEGB);
   assign seg      = SEGB'(offs >> shamt);
   assign hit      = en_q && (((addr ^ base_q) & hmask) == '0);
   assign low_keep = ~hmask[MAXL-1:0];
   assign pci      = AW'((repl_q & ~low_keep) | (addr[MAXL-1:0] & low_keep));

endmodule

// File: rtl/mwd_prio.sv
module mwd_prio #(
   parameter int AW   = 48,
   parameter int N64  = 16,
   parameter int PEW  = 8,
   localparam int WINW = $clog2(N64 + 1)
) (
   input  logic [N64-1:0]           hit_w,
   input  logic [N64-1:0][PEW-1:0]  pe_w,
   input  logic                     hit_n,
   input  logic [PEW-1:0]           pe_n,
   input  logic [AW-1:0]            pci_n,
   input  logic [AW-1:0]            addr,
   output logic                     hit,
   output logic [WINW-1:0]          win,
   output logic [PEW-1:0]           pe,
   output logic [AW-1:0]            pci
);

   always_comb begin
      hit = 1'b0;
      win = '0;
      pe  = '0;
      pci = '0;
      if (hit_n) begin
         hit = 1'b1;
         win = WINW'(N64);
         pe  = pe_n;
         pci = pci_n;
      end
      // Walk from the highest index down so the lowest claiming window wins.
      for (int k = N64 - 1; k >= 0; k--) begin
         if (hit_w[k]) begin
            hit = 1'b1;
            win = WINW'(k);
            pe  = pe_w[k];
            pci = addr;
         end
      end
   end

endmodule

// File: rtl/mmio_win_decoder.sv
module mmio_win_decoder #(
   parameter int AW           = 48,
   parameter int N64          = 16,
   parameter int NSEG         = 256,
   parameter int PEW          = 8,
   parameter int W32_MIN_LOG2 = 16,
   parameter int W64_MIN_LOG2 = 28,
   localparam int WINW        = $clog2(N64 + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [10:0]     cfg_addr,
   input  logic [63:0]     cfg_wdata,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_addr,
   output logic            rsp_valid,
   output logic            rsp_hit,
   output logic [WINW-1:0] rsp_win,
   output logic [PEW-1:0]  rsp_pe,
   output logic [AW-1:0]   rsp_pci_addr
);
   import mwd_pkg::*;

   localparam int SEGB = $clog2(NSEG);

   // Elaboration-time parameter checks.
   if (AW < 33 || AW > 63) begin : g_bad_aw
      $error("AW must lie in 33..63");
   end
   if (N64 < 1 || N64 > (1 << CFG_IDXW)) begin : g_bad_n64
      $error("N64 must lie in 1..256");
   end
   if ((1 << SEGB) != NSEG || NSEG > (1 << CFG_IDXW) || NSEG < 2) begin : g_bad_nseg
      $error("NSEG must be a power of two in 2..256");
   end
   if (PEW < SEGB || PEW > 8) begin : g_bad_pew
      $error("PEW must hold a segment index and fit in eight bits");
   end
   if (W64_MIN_LOG2 < SEGB || W64_MIN_LOG2 > AW) begin : g_bad_w64min
      $error("W64_MIN_LOG2 out of range");
   end
   if (W32_MIN_LOG2 < SEGB || W32_MIN_LOG2 > 32) begin : g_bad_w32min
      $error("W32_MIN_LOG2 out of range");
   end

   // Configuration decode.
   cfg_sel_e              sel;
   logic [CFG_IDXW-1:0]   idx;
   logic                  unused_cfg;

   assign sel        = cfg_sel_e'(cfg_addr[CFG_AW-1:CFG_IDXW]);
   assign idx        = cfg_addr[CFG_IDXW-1:0];
   assign unused_cfg = ^cfg_wdata;

   // Wide windows.
   logic [N64-1:0]          hit_w;
   logic [N64-1:0][PEW-1:0] pe_w;

   for (genvar k = 0; k < N64; k++) begin : g_wide
      logic sel_me;
      assign sel_me = cfg_we && (idx == CFG_IDXW'(k));

      mwd_win_wide #(
         .AW   (AW),
         .PEW  (PEW),
         .SEGB (SEGB),
         .MINL (W64_MIN_LOG2)
      ) u_win (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_base (sel_me && sel == SEL_W_BASE),
         .we_ctrl (sel_me && sel == SEL_W_CTRL),
         .d_base  (cfg_wdata[AW-1:0]),
         .d_en    (cfg_wdata[0]),
         .d_segm  (cfg_wdata[1]),
         .d_lg    (cfg_wdata[8 +: LGW]),
         .d_pe    (cfg_wdata[16 +: PEW]),
         .addr    (req_addr),
         .hit     (hit_w[k]),
         .pe      (pe_w[k])
      );
   end

   // Narrow window and its segment table.
   logic            hit_n;
   logic [SEGB-1:0] seg_n;
   logic [AW-1:0]   pci_n;
   logic [PEW-1:0]  pe_n;

   mwd_win_narrow #(
      .AW   (AW),
      .SEGB (SEGB),
      .MINL (W32_MIN_LOG2)
   ) u_narrow (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_base (cfg_we && sel == SEL_N_BASE),
      .we_ctrl (cfg_we && sel == SEL_N_CTRL),
      .d_base  (cfg_wdata[AW-1:0]),
      .d_en    (cfg_wdata[0]),
      .d_lg    (cfg_wdata[8 +: LGW]),
      .d_repl  (cfg_wdata[63:32]),
      .addr    (req_addr),
      .hit     (hit_n),
      .seg     (seg_n),
      .pci     (pci_n)
   );

   mwd_seg_table #(
      .NSEG (NSEG),
      .PEW  (PEW)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we && sel == SEL_SEGTAB),
      .widx  (idx[SEGB-1:0]),
      .wpe   (cfg_wdata[PEW-1:0]),
      .ridx  (seg_n),
      .rpe   (pe_n)
   );

   // Priority resolution.
   logic            hit_c;
   logic [WINW-1:0] win_c;
   logic [PEW-1:0]  pe_c;
   logic [AW-1:0]   pci_c;

   mwd_prio #(
      .AW  (AW),
      .N64 (N64),
      .PEW (PEW)
   ) u_prio (
      .hit_w (hit_w),
      .pe_w  (pe_w),
      .hit_n (hit_n),
      .pe_n  (pe_n),
      .pci_n (pci_n),
      .addr  (req_addr),
      .hit   (hit_c),
      .win   (win_c),
      .pe    (pe_c),
      .pci   (pci_c)
   );

   // Result register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_win      <= '0;
         rsp_pe       <= '0;
         rsp_pci_addr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit      <= hit_c;
            rsp_win      <= win_c;
            rsp_pe       <= pe_c;
            rsp_pci_addr <= pci_c;
         end
      end
   end

endmodule

// File: rtl/mmio_win_decoder_chk.sv
module mmio_win_decoder_chk #(
   parameter int AW   = 48,
   parameter int N64  = 16,
   parameter int PEW  = 8,
   parameter int WINW = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [AW-1:0]   req_addr,
   input logic            rsp_valid,
   input logic            rsp_hit,
   input logic [WINW-1:0] rsp_win,
   input logic [PEW-1:0]  rsp_pe,
   input logic [AW-1:0]   rsp_pci_addr
);

   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_wide_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!(rsp_hit && int'(rsp_win) < N64) || rsp_pci_addr == $past(req_addr)));

   assert_narrow_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && int'(rsp_win) == N64) |-> rsp_pci_addr[AW-1:32] == '0);

   assert_miss_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_pe == '0 && rsp_pci_addr == '0 && rsp_win == '0));

   assert_win_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> int'(rsp_win) <= N64);

endmodule

bind mmio_win_decoder mmio_win_decoder_chk #(
   .AW   (AW),
   .N64  (N64),
   .PEW  (PEW),
   .WINW (WINW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_win      (rsp_win),
   .rsp_pe       (rsp_pe),
   .rsp_pci_addr (rsp_pci_addr)
);

// File: tb/tb_mmio_win_decoder.sv
module tb_mmio_win_decoder;

   localparam int AW   = 48;
   localparam int N64  = 4;
   localparam int PEW  = 8;
   localparam int WINW = $clog2(N64 + 1);
   localparam logic [WINW-1:0] NWIN = WINW'(N64);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [10:0]     cfg_addr = '0;
   logic [63:0]     cfg_wdata = '0;
   logic            req_valid = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic            rsp_valid;
   logic            rsp_hit;
   logic [WINW-1:0] rsp_win;
   logic [PEW-1:0]  rsp_pe;
   logic [AW-1:0]   rsp_pci_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   mmio_win_decoder #(
      .AW           (AW),
      .N64          (N64),
      .NSEG         (256),
      .PEW          (PEW),
      .W32_MIN_LOG2 (16),
      .W64_MIN_LOG2 (20)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .rsp_valid    (rsp_valid),
      .rsp_hit      (rsp_hit),
      .rsp_win      (rsp_win),
      .rsp_pe       (rsp_pe),
      .rsp_pci_addr (rsp_pci_addr)
   );

   function automatic logic [63:0] wide_ctl(input bit en, input bit segm,
                                            input int lg, input logic [7:0] pe);
      return 64'(en) | (64'(segm) << 1) | (64'(lg) << 8) | (64'(pe) << 16);
   endfunction

   function automatic logic [63:0] narrow_ctl(input bit en, input int lg,
                                              input logic [31:0] repl);
      return 64'(en) | (64'(lg) << 8) | ({32'b0, repl} << 32);
   endfunction

   task automatic cfg_wr(input logic [2:0] sel, input logic [7:0] idx, input logic [63:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = {sel, idx};
      cfg_wdata = d;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic chk_rsp(input string tag, input bit hit, input logic [WINW-1:0] win,
                          input logic [PEW-1:0] pe, input logic [AW-1:0] pci);
      n_chk++;
      if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_win !== win ||
          rsp_pe !== pe || rsp_pci_addr !== pci) begin
         n_bad++;
         $display("FAIL %s: actual v=%0b hit=%0b win=%0d pe=%h pci=%h expected v=1 hit=%0b win=%0d pe=%h pci=%h",
                  tag, rsp_valid, rsp_hit, rsp_win, rsp_pe, rsp_pci_addr, hit, win, pe, pci);
      end
   endtask

   task automatic lookup(input logic [AW-1:0] a, input string tag, input bit hit,
                         input logic [WINW-1:0] win, input logic [PEW-1:0] pe,
                         input logic [AW-1:0] pci);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk_rsp(tag, hit, win, pe, pci);
   endtask

   // R1, R11: nothing claims an address out of reset.
   task automatic t_reset();
      n_chk++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: actual v=%0b hit=%0b expected v=0 hit=0", rsp_valid, rsp_hit);
      end
      lookup(48'h0000_C000_1234, "R1 miss after reset", 0, '0, '0, '0);
      lookup(48'h0010_0530_0123, "R11 miss clean", 0, '0, '0, '0);
   endtask

   // R3, R4, R5: segmented wide window, base carries junk below its size.
   task automatic t_wide_seg();
      cfg_wr(3'd3, 8'd0, 64'h0010_0000_0ABC);
      cfg_wr(3'd4, 8'd0, wide_ctl(1, 1, 28, 8'h00));
      lookup(48'h0010_0530_0123, "R5 segment pe", 1, 3'd0, 8'h53, 48'h0010_0530_0123);
      lookup(48'h0010_1000_0000, "R3 just past window", 0, '0, '0, '0);
      lookup(48'h0010_0000_0000, "R4 first byte", 1, 3'd0, 8'h00, 48'h0010_0000_0000);
   endtask

   // R6: unsegmented wide window.
   task automatic t_wide_whole();
      cfg_wr(3'd3, 8'd1, 64'h0020_0000_0000);
      cfg_wr(3'd4, 8'd1, wide_ctl(1, 0, 30, 8'h7A));
      lookup(48'h0020_3FFF_FFF0, "R6 fixed pe", 1, 3'd1, 8'h7A, 48'h0020_3FFF_FFF0);
   endtask

   // R7: overlapping wide windows.
   task automatic t_wide_prio();
      cfg_wr(3'd3, 8'd2, 64'h0010_0000_0000);
      cfg_wr(3'd4, 8'd2, wide_ctl(1, 0, 32, 8'h11));
      lookup(48'h0010_0530_0123, "R7 lower index wins", 1, 3'd0, 8'h53, 48'h0010_0530_0123);
      lookup(48'h0010_2000_0000, "R7 only outer window", 1, 3'd2, 8'h11, 48'h0010_2000_0000);
      cfg_wr(3'd4, 8'd0, wide_ctl(0, 1, 28, 8'h00));
      lookup(48'h0010_0530_0123, "R7 after disabling window 0", 1, 3'd2, 8'h11, 48'h0010_0530_0123);
   endtask

   // R3: a size code below the minimum is raised to it.
   task automatic t_wide_clamp();
      cfg_wr(3'd3, 8'd3, 64'h0030_0000_0000);
      cfg_wr(3'd4, 8'd3, wide_ctl(1, 1, 4, 8'h00));
      lookup(48'h0030_000F_FFFF, "R3 clamped size last segment", 1, 3'd3, 8'hFF, 48'h0030_000F_FFFF);
      lookup(48'h0030_0010_0000, "R3 clamped size edge", 0, '0, '0, '0);
   endtask

   // R2: back-to-back requests, then an idle cycle.
   task automatic t_stream();
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 48'h0010_2000_0000;
      @(negedge clk);
      req_addr  = 48'h0020_3FFF_FFF0;
      chk_rsp("R2 first of pair", 1, 3'd2, 8'h11, 48'h0010_2000_0000);
      @(negedge clk);
      req_valid = 1'b0;
      chk_rsp("R2 second of pair", 1, 3'd1, 8'h7A, 48'h0020_3FFF_FFF0);
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R2 idle: actual v=%0b expected v=0", rsp_valid);
      end
   endtask

   // R8, R9, R10, R1: narrow window with segment table.
   task automatic t_narrow();
      cfg_wr(3'd2, 8'd5,   64'h42);
      cfg_wr(3'd2, 8'd255, 64'h99);
      cfg_wr(3'd0, 8'd0,   64'h0000_C000_0000);
      cfg_wr(3'd1, 8'd0,   narrow_ctl(1, 30, 32'h8000_1234));
      lookup(48'h0000_C140_0010, "R10 table entry 5, R9 replace", 1, NWIN, 8'h42, 48'h0000_8140_0010);
      lookup(48'h0000_FFFF_FFFC, "R10 last segment", 1, NWIN, 8'h99, 48'h0000_BFFF_FFFC);
      lookup(48'h0000_C040_0000, "R1 unwritten table entry", 1, NWIN, 8'h00, 48'h0000_8040_0000);
      lookup(48'h0001_C040_0000, "R9 upper bits must match base", 0, '0, '0, '0);
   endtask

   // R8: a wide window shadows part of the narrow window.
   task automatic t_shadow();
      cfg_wr(3'd3, 8'd1, 64'h0000_C000_0000);
      cfg_wr(3'd4, 8'd1, wide_ctl(1, 0, 20, 8'h7A));
      lookup(48'h0000_C000_0100, "R8 wide beats narrow", 1, 3'd1, 8'h7A, 48'h0000_C000_0100);
      lookup(48'h0000_C140_0010, "R8 narrow outside shadow", 1, NWIN, 8'h42, 48'h0000_8140_0010);
   endtask

   // R12: selector 2 with a nonzero index writes only that table entry.
   task automatic t_encoding();
      cfg_wr(3'd2, 8'd6, 64'hFFFF_FFFF_FFFF_FF3C);
      lookup(48'h0000_C180_0000, "R12 table write field", 1, NWIN, 8'h3C, 48'h0000_8180_0000);
      lookup(48'h0000_C140_0010, "R12 neighbour entry kept", 1, NWIN, 8'h42, 48'h0000_8140_0010);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wide_seg();
      t_wide_whole();
      t_wide_prio();
      t_wide_clamp();
      t_stream();
      t_narrow();
      t_shadow();
      t_encoding();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule